// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches one external interrupt pin and turns its activity into an interrupt request for a CPU core. The pin is sampled through a synchronizer, so its sensed value is used whatever direction the pad is driven in. A 2-bit sense-select input chooses what counts as an event: a low level, any change, a falling edge or a rising edge. In the edge and any-change modes an event sets a pending flag. The flag is cleared either by software writing a one to it or by the CPU acknowledging the vector. In low-level mode there is no flag, and the request follows the synchronized pin directly.

A small register bus gives access to two 8-bit registers. The enable register sits at address 0x13, and the pending-flag register sits at 0x14. The request reaches the CPU only when the per-source enable bit and the global interrupt-enable input are both one. There is no streaming data path. The bus, the acknowledge and the request are plain single-cycle control signals with no handshake and no back-pressure.

Top module: `xpin_irq`

## Requirements
- R1: After reset the enable register and the flag register both read 0x00, and `irq_req` is 0.
- R2: The enable bit is bit 0 of address 0x13. A write stores `reg_wdata[0]`. Bits 7:1 always read zero and ignore writes. Any address other than 0x13 and 0x14 reads 0x00.
- R3: With `sense_sel` = 2'b01, every change of the pin sets the flag (bit 0 of 0x14). The flag is visible three rising clock edges after the pin changes.
- R4: With `sense_sel` = 2'b10, a high-to-low pin change sets the flag and a low-to-high change does not.
- R5: With `sense_sel` = 2'b11, a low-to-high pin change sets the flag and a high-to-low change does not.
- R6: With `sense_sel` = 2'b00, the flag reads 0, and `irq_req` equals `gie & enable & ~pin`. The pin term lags `pin_in` by two rising edges, and `irq_ack` has no effect.
- R7: A bus write to 0x14 with data bit 0 set clears the flag. A write to 0x14 with data bit 0 clear leaves it unchanged. Bits 7:1 of 0x14 always read zero.
- R8: In an edge or any-change mode, a one-cycle `irq_ack` pulse clears the flag.
- R9: In the edge and any-change modes, `irq_req` equals `flag & enable & gie`. The request is never asserted unless both `gie` and the enable bit are one.
- R10: If a qualifying pin event is seen in the same cycle as a clear, whether by write-one or by acknowledge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Sensed level of the external pin (asynchronous) |
| sense_sel | input | 2 | Event select: 00 low level, 01 any change, 10 falling, 11 rising |
| gie | input | 1 | Global interrupt enable from the CPU |
| irq_ack | input | 1 | CPU entering the vector; clears the flag in edge modes |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | AW (6) | Register address |
| reg_wdata | input | DW (8) | Register write data |
| reg_rdata | output | DW (8) | Register read data, combinational from `reg_addr` |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
The function most likely to fail is a pin event that lands in the same clock cycle as a flag clear, from either the write-one path or the acknowledge path. The bench provokes this by changing the pin exactly two rising edges before it drives the clearing write or the acknowledge pulse, so that the synchronized edge and the clear reach the flag register on the same edge. A correct design keeps the flag set, and a second clear with the pin quiet then drops the flag to zero. The random phase mixes pin toggles, acknowledges and writes freely, and a cycle-level model in the bench scores every one of these overlaps.

// File: rtl/xpin_irq_pkg.sv
package xpin_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int BUS_AW = 6;
  localparam int BUS_DW = 8;
endpackage

// File: rtl/xpin_sync.sv
module xpin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[0] <= RST_VAL;
        else        sr[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[i] <= RST_VAL;
        else        sr[i] <= sr[i-1];
      end
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/xpin_event.sv
module xpin_event
  import xpin_irq_pkg::*;
#(
  parameter logic RST_VAL = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_s,
  input  sense_e sense,
  output logic   evt
);
  logic pin_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= RST_VAL;
    else        pin_prev <= pin_s;
  end

  // the low-level mode produces no event; the flag stays idle there
  always_comb begin
    unique case (sense)
      SENSE_ANY:  evt = pin_s ^ pin_prev;
      SENSE_FALL: evt = pin_prev & ~pin_s;
      SENSE_RISE: evt = ~pin_prev & pin_s;
      default:    evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/xpin_regs.sv
module xpin_regs #(
  parameter int             AW        = 6,
  parameter int             DW        = 8,
  parameter logic [AW-1:0]  MASK_ADDR = 'h13,
  parameter logic [AW-1:0]  FLAG_ADDR = 'h14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          evt,
  input  logic          level_mode,
  input  logic          ack,
  output logic          en,
  output logic          flag
);
  localparam logic [DW-1:0] BIT0 = DW'(1);

  logic [DW-1:0] en_r;
  logic          flag_r;
  logic          wr_mask, wr_flag, clr;

  assign wr_mask = wen && (addr == MASK_ADDR);
  assign wr_flag = wen && (addr == FLAG_ADDR);
  assign clr     = (wr_flag && |(wdata & BIT0)) || ack;

  // only bit 0 is implemented; the rest is held at zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_r <= '0;
    else if (wr_mask) en_r <= wdata & BIT0;
  end

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_r <= 1'b0;
    else if (level_mode) flag_r <= 1'b0;
    else                 flag_r <= (flag_r & ~clr) | evt;
  end

  always_comb begin
    if (addr == MASK_ADDR)      rdata = en_r;
    else if (addr == FLAG_ADDR) rdata = DW'(flag_r & ~level_mode);
    else                        rdata = '0;
  end

  assign en   = en_r[0];
  assign flag = flag_r;
endmodule

// File: rtl/xpin_irq.sv
module xpin_irq
  import xpin_irq_pkg::*;
#(
  parameter int            AW          = BUS_AW,
  parameter int            DW          = BUS_DW,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] MASK_ADDR   = 'h13,
  parameter logic [AW-1:0] FLAG_ADDR   = 'h14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic [1:0]    sense_sel,
  input  logic          gie,
  input  logic          irq_ack,
  input  logic          reg_wen,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_req
);
  sense_e sense;
  logic   pin_s, evt, level_mode, en_q, flag_q;

  assign sense      = sense_e'(sense_sel);
  assign level_mode = (sense == SENSE_LOW);

  xpin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  xpin_event #(.RST_VAL(1'b1)) u_event (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .sense(sense), .evt(evt)
  );

  xpin_regs #(
    .AW(AW), .DW(DW), .MASK_ADDR(MASK_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .evt(evt),
    .level_mode(level_mode), .ack(irq_ack), .en(en_q), .flag(flag_q)
  );

  assign irq_req = gie & en_q & (level_mode ? ~pin_s : flag_q);
endmodule

// File: rtl/xpin_irq_chk.sv
module xpin_irq_chk #(
  parameter int            AW        = 6,
  parameter logic [AW-1:0] MASK_ADDR = 'h13,
  parameter logic [AW-1:0] FLAG_ADDR = 'h14
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    sense_sel,
  input logic          gie,
  input logic          irq_ack,
  input logic          reg_wen,
  input logic [AW-1:0] reg_addr,
  input logic          wr_bit0,
  input logic          irq_req,
  input logic          pin_s,
  input logic          evt,
  input logic          en_q,
  input logic          flag_q
);
  logic lvl, flag_w1;
  assign lvl     = (sense_sel == 2'b00);
  assign flag_w1 = reg_wen && (reg_addr == FLAG_ADDR) && wr_bit0;

  assert_req_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gie && en_q));

  assert_level_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl && gie && en_q && !pin_s) |-> irq_req);

  assert_level_noflag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl && $past(lvl)) |-> !flag_q);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !lvl && !evt) |=> !flag_q);

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_w1 && !evt) |=> !flag_q);

  assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !lvl && !irq_ack && !flag_w1) |=> flag_q);

  assert_event_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !lvl) |=> flag_q);

  assert_mask_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == MASK_ADDR) |=> (en_q == $past(wr_bit0)));
endmodule

bind xpin_irq xpin_irq_chk #(
  .AW(AW), .MASK_ADDR(MASK_ADDR), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sense_sel(sense_sel), .gie(gie),
  .irq_ack(irq_ack), .reg_wen(reg_wen), .reg_addr(reg_addr),
  .wr_bit0(reg_wdata[0]), .irq_req(irq_req), .pin_s(pin_s), .evt(evt),
  .en_q(en_q), .flag_q(flag_q)
);

// File: tb/sim_xpin_irq.sv
`timescale 1ns/1ps
module sim_xpin_irq;
  localparam logic [5:0] A_MASK = 6'h13;
  localparam logic [5:0] A_FLAG = 6'h14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic [1:0] sense = 2'b00;
  logic       gie = 1'b0, ack = 1'b0, wen = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  xpin_irq u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin), .sense_sel(sense), .gie(gie),
    .irq_ack(ack), .reg_wen(wen), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_req(irq)
  );

  // cycle model built from the requirements: two-edge pin lag, flag on third edge
  logic m_s1, m_s2, m_p, m_flag, m_en;

  function automatic logic hit(input logic [1:0] s, input logic p, input logic c);
    case (s)
      2'b01:   return p ^ c;
      2'b10:   return p & ~c;
      2'b11:   return ~p & c;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_p <= 1'b1; m_flag <= 1'b0; m_en <= 1'b0;
    end else begin
      m_s1 <= pin; m_s2 <= m_s1; m_p <= m_s2;
      if (wen && addr == A_MASK) m_en <= wdata[0];
      if (sense == 2'b00) m_flag <= 1'b0;
      else m_flag <= (m_flag & ~(ack | (wen && addr == A_FLAG && wdata[0])))
                     | hit(sense, m_p, m_s2);
    end
  end

  function automatic logic [7:0] exp_rd();
    if (addr == A_MASK) return {7'b0, m_en};
    if (addr == A_FLAG) return {7'b0, m_flag & (sense != 2'b00)};
    return 8'h00;
  endfunction

  function automatic logic exp_irq();
    return gie & m_en & ((sense == 2'b00) ? ~m_s2 : m_flag);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    wen = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    rd(A_MASK, v); chk("R1 mask", v, 8'h00);
    rd(A_FLAG, v); chk("R1 flag", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2 enable register, reserved bits, unused address
    wr(A_MASK, 8'hFF); rd(A_MASK, v); chk("R2 mask ff", v, 8'h01);
    wr(A_MASK, 8'hFE); rd(A_MASK, v); chk("R2 mask fe", v, 8'h00);
    rd(6'h15, v); chk("R2 unused addr", v, 8'h00);
    wr(A_MASK, 8'h01); gie = 1'b1;

    // R3 any change, latency of three edges
    sense = 2'b01; tick(1);
    pin = 1'b0; tick(2); rd(A_FLAG, v); chk("R3 before latency", v, 8'h00);
    tick(1); rd(A_FLAG, v); chk("R3 fall sets", v, 8'h01);
    chk("R9 irq on flag", {7'b0, irq}, 8'h01);
    wr(A_FLAG, 8'h01);
    pin = 1'b1; tick(3); rd(A_FLAG, v); chk("R3 rise sets", v, 8'h01);
    wr(A_FLAG, 8'h01);

    // R4 falling only
    sense = 2'b10; tick(1);
    pin = 1'b0; tick(3); rd(A_FLAG, v); chk("R4 fall sets", v, 8'h01);
    wr(A_FLAG, 8'h01);
    pin = 1'b1; tick(3); rd(A_FLAG, v); chk("R4 rise ignored", v, 8'h00);

    // R5 rising only
    sense = 2'b11; tick(1);
    pin = 1'b0; tick(3); rd(A_FLAG, v); chk("R5 fall ignored", v, 8'h00);
    pin = 1'b1; tick(3); rd(A_FLAG, v); chk("R5 rise sets", v, 8'h01);

    // R7 write zero keeps, write one clears
    wr(A_FLAG, 8'hFE); rd(A_FLAG, v); chk("R7 write zero keeps", v, 8'h01);
    wr(A_FLAG, 8'h01); rd(A_FLAG, v); chk("R7 write one clears", v, 8'h00);

    // R8 acknowledge clears
    pin = 1'b0; tick(3); pin = 1'b1; tick(3);
    rd(A_FLAG, v); chk("R8 flag set", v, 8'h01);
    pulse_ack(); rd(A_FLAG, v); chk("R8 ack clears", v, 8'h00);
    chk("R8 irq drops", {7'b0, irq}, 8'h00);

    // R9 gating
    pin = 1'b0; tick(3); pin = 1'b1; tick(3);
    wr(A_MASK, 8'h00); chk("R9 enable off", {7'b0, irq}, 8'h00);
    gie = 1'b0; wr(A_MASK, 8'h01); chk("R9 gie off", {7'b0, irq}, 8'h00);
    gie = 1'b1; #1; chk("R9 both on", {7'b0, irq}, 8'h01);

    // R10 event meets write-one clear
    pin = 1'b0; tick(3);
    pin = 1'b1; tick(2); wr(A_FLAG, 8'h01);
    rd(A_FLAG, v); chk("R10 w1c clash keeps", v, 8'h01);
    wr(A_FLAG, 8'h01); rd(A_FLAG, v); chk("R10 later clear", v, 8'h00);
    // R10 event meets acknowledge
    pin = 1'b0; tick(3);
    pin = 1'b1; tick(2); pulse_ack();
    rd(A_FLAG, v); chk("R10 ack clash keeps", v, 8'h01);

    // R6 level mode
    sense = 2'b00; #1;
    rd(A_FLAG, v); chk("R6 flag hidden", v, 8'h00);
    chk("R6 pin high", {7'b0, irq}, 8'h00);
    pin = 1'b0; tick(1); chk("R6 one edge lag", {7'b0, irq}, 8'h00);
    tick(1); chk("R6 low requests", {7'b0, irq}, 8'h01);
    rd(A_FLAG, v); chk("R6 flag zero", v, 8'h00);
    pulse_ack(); chk("R6 ack no effect", {7'b0, irq}, 8'h01);
    pin = 1'b1; tick(2); chk("R6 high releases", {7'b0, irq}, 8'h00);

    // mixed random phase scored against the model (R3..R10)
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      #1;
      chk("R9 random irq", {7'b0, irq}, {7'b0, exp_irq()});
      chk("R7 random read", rdata, exp_rd());
      if ($urandom_range(0, 3) == 0) pin = ~pin;
      if ($urandom_range(0, 60) == 0) sense = 2'($urandom_range(0, 3));
      gie = ($urandom_range(0, 7) != 0);
      ack = ($urandom_range(0, 7) == 0);
      wen = ($urandom_range(0, 4) == 0);
      case ($urandom_range(0, 2))
        0: addr = A_MASK;
        1: addr = A_FLAG;
        default: addr = 6'h12;
      endcase
      wdata = ($urandom_range(0, 9) == 0) ? 8'h00 : 8'($urandom);
    end
    wen = 1'b0; ack = 1'b0;
    tick(2);
    finish_run();
  end
endmodule